// File: doc/BRIEF.md
# Cache Parameter Explorer

This block searches for good cache settings while the processor runs a workload. It places a candidate setting on its configuration output and pulses a trial-start strobe. It then waits for the cache side to report the hit count, the miss count and the cycle count of that trial. From these it forms a figure of merit. In the energy pass the figure is an energy estimate built from per-setting cost constants that an external table supplies for the setting currently on the output. In the speed pass the figure is simply the cycle count.

The search is greedy. It visits one parameter at a time and walks its option index upward from the value it holds. A step is kept while it strictly lowers the figure. At the first step that fails to improve, the previous value is restored and the next parameter is taken up. The number of trials therefore grows with the sum of the option counts, not their product. The energy pass covers cache size, then line size, then associativity, then way prediction. The speed pass keeps the size that the energy pass chose, turns way prediction off, and revisits line size and then associativity. When both passes are finished, the block holds the lowest-energy setting on its output, raises a done flag and waits for a new start.

Top module: `cache_explorer`

## Requirements
- R1: After reset, done and trialStart are low and cfgOut is zero.
- R2: A start pulse while idle or done launches a trial with cfgOut all zero. trialStart is high for exactly one cycle per trial. cfgOut stays constant while a trial is pending.
- R3: The energy of a trial equals hitCount*hitCost + missCount*missCost + cycleCount*staticCost. bestEnergyVal reports this value for the configuration in bestEnergyCfg.
- R4: The cfgOut field layout is: bits [1:0] size index, [3:2] line index, [5:4] associativity index, bit 6 way prediction. The energy pass steps these fields in the order size, line, associativity, way prediction. Each step raises the field by one from its kept value.
- R5: A step is kept only if its figure is strictly lower than the best figure so far. After a step that does not improve, the next trial carries the restored field and the next parameter already at index 1. A parameter also ends when its last option is reached.
- R6: An equal figure does not replace the best one, so the earlier, smaller option index is kept.
- R7: The speed pass starts from the chosen size with line, associativity and way prediction at zero. It steps line, then associativity, using cycleCount as the figure. Bit 6 stays 0 throughout this pass. bestTimeCfg and bestTimeVal report its result.
- R8: When the search is finished, done is high, cfgOut equals bestEnergyCfg, and no further trial starts until the next start pulse.
- R9: A full search takes exactly one baseline trial per pass plus one trial per step taken, and no other trials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new search when idle or done |
| trialDone | input | 1 | One-cycle strobe: the trial counts are valid |
| hitCount | input | 16 | Hits counted in the trial |
| missCount | input | 16 | Misses counted in the trial |
| cycleCount | input | 16 | Cycles the trial took |
| hitCost | input | 8 | Energy per hit for the current cfgOut |
| missCost | input | 8 | Energy per miss for the current cfgOut |
| staticCost | input | 8 | Static energy per cycle for the current cfgOut |
| trialStart | output | 1 | One-cycle pulse that launches a trial |
| cfgOut | output | 7 | Configuration presented to the cache |
| done | output | 1 | Search finished |
| bestEnergyCfg | output | 7 | Lowest-energy configuration found |
| bestEnergyVal | output | 26 | Its energy figure |
| bestTimeCfg | output | 7 | Fastest configuration found |
| bestTimeVal | output | 26 | Its cycle count |

## Verification
Two things happen in the same decision cycle: one parameter's field is restored after a step that did not improve, and the next parameter's field moves to index 1. Several count profiles are therefore driven so that improvement stops in the middle of a range, stops at the end of a range, or fails at the very first step. A flat profile produces exact ties. The first trial after each such decision must show both fields updated together. The expected list of configurations, trial by trial, is derived in the bench from arithmetic count and cost formulas.

// File: rtl/explorer_pkg.sv
package explorer_pkg;
  typedef struct packed {
    logic       capture;     // latch counts and costs of the finished trial
    logic       accClr;      // first energy term replaces the accumulator
    logic       accEn;       // accumulator takes a term this cycle
    logic [1:0] termSel;     // 0 hit term, 1 miss term, 2 static term
    logic       timeMetric;  // figure of merit is the cycle count
    logic       loadRun;     // running best takes the current figure
    logic       loadFirst;   // this load is a pass baseline
    logic       loadEnergy;  // store energy result
    logic       loadTime;    // store speed result
  } ctlStrobes_t;
endpackage

// File: rtl/explorer_datapath.sv
module explorer_datapath
  import explorer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int COST_W   = 8,
  parameter int ENERGY_W = CNT_W + COST_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic [CNT_W-1:0]    hitCount,
  input  logic [CNT_W-1:0]    missCount,
  input  logic [CNT_W-1:0]    cycleCount,
  input  logic [COST_W-1:0]   hitCost,
  input  logic [COST_W-1:0]   missCost,
  input  logic [COST_W-1:0]   staticCost,
  output logic                better,
  output logic [ENERGY_W-1:0] bestEnergyVal,
  output logic [ENERGY_W-1:0] bestTimeVal
);
  logic [CNT_W-1:0]    hitR, missR, cycR;
  logic [COST_W-1:0]   hitCostR, missCostR, staticCostR;
  logic [CNT_W-1:0]    mulA;
  logic [COST_W-1:0]   mulB;
  logic [ENERGY_W-1:0] product, acc, metric, runBest;

  always_comb begin
    unique case (ctl.termSel)
      2'd0:    begin mulA = hitR;  mulB = hitCostR;    end
      2'd1:    begin mulA = missR; mulB = missCostR;   end
      default: begin mulA = cycR;  mulB = staticCostR; end
    endcase
  end

  assign product = {{(ENERGY_W-CNT_W){1'b0}}, mulA} * {{(ENERGY_W-COST_W){1'b0}}, mulB};
  assign metric  = ctl.timeMetric ? {{(ENERGY_W-CNT_W){1'b0}}, cycR} : acc;
  assign better  = metric < runBest;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitR <= '0; missR <= '0; cycR <= '0;
      hitCostR <= '0; missCostR <= '0; staticCostR <= '0;
      acc <= '0; runBest <= '0; bestEnergyVal <= '0; bestTimeVal <= '0;
    end else begin
      if (ctl.capture) begin
        hitR <= hitCount; missR <= missCount; cycR <= cycleCount;
        hitCostR <= hitCost; missCostR <= missCost; staticCostR <= staticCost;
      end
      if (ctl.accEn) acc <= ctl.accClr ? product : acc + product;
      if (ctl.loadRun) runBest <= metric;
      if (ctl.loadEnergy) bestEnergyVal <= runBest;
      if (ctl.loadTime) bestTimeVal <= runBest;
    end
  end

  // a kept step must strictly lower the running best
  p_best_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadRun && !ctl.loadFirst) |=> (runBest < $past(runBest)));

  // the energy figure is built from exactly three terms, hit term first
  p_term_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accEn && ctl.accClr) |-> (ctl.termSel == 2'd0));
endmodule

// File: rtl/explorer_ctrl.sv
module explorer_ctrl
  import explorer_pkg::*;
#(
  parameter int NUM_SIZE  = 3,
  parameter int NUM_LINE  = 3,
  parameter int NUM_ASSOC = 3,
  parameter int FW        = 2,
  parameter int CFG_W     = 3 * FW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             trialDone,
  input  logic             better,
  output ctlStrobes_t      ctl,
  output logic             trialStart,
  output logic [CFG_W-1:0] cfgOut,
  output logic             done,
  output logic [CFG_W-1:0] bestEnergyCfg,
  output logic [CFG_W-1:0] bestTimeCfg
);
  typedef enum logic [3:0] {
    S_IDLE, S_LAUNCH, S_WAIT, S_MUL0, S_MUL1, S_MUL2, S_DECIDE, S_FINISH, S_DONE
  } state_t;

  state_t         state;
  logic [FW-1:0]  cur [4];
  logic [1:0]     paramIdx;
  logic           timePass, baseline, lastParam, canStep;
  logic [CFG_W-1:0] cfgWord;

  function automatic int optCount(input logic [1:0] idx);
    case (idx)
      2'd0:    return NUM_SIZE;
      2'd1:    return NUM_LINE;
      2'd2:    return NUM_ASSOC;
      default: return 2;
    endcase
  endfunction

  for (genvar g = 0; g < 3; g++) begin : g_pack
    assign cfgWord[g*FW +: FW] = cur[g];
  end
  assign cfgWord[3*FW] = cur[3][0];

  assign lastParam = timePass ? (paramIdx == 2'd2) : (paramIdx == 2'd3);
  assign canStep   = (int'(cur[paramIdx]) + 1) < optCount(paramIdx);

  always_comb begin
    ctl            = '0;
    ctl.capture    = (state == S_WAIT) && trialDone;
    ctl.accEn      = (state == S_MUL0) || (state == S_MUL1) || (state == S_MUL2);
    ctl.accClr     = (state == S_MUL0);
    ctl.termSel    = (state == S_MUL1) ? 2'd1 : (state == S_MUL2) ? 2'd2 : 2'd0;
    ctl.timeMetric = timePass;
    ctl.loadRun    = (state == S_DECIDE) && (baseline || better);
    ctl.loadFirst  = baseline;
    ctl.loadEnergy = (state == S_FINISH) && !timePass;
    ctl.loadTime   = (state == S_FINISH) && timePass;
  end

  assign trialStart = (state == S_LAUNCH);
  assign done       = (state == S_DONE);
  assign cfgOut     = cfgWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      for (int i = 0; i < 4; i++) cur[i] <= '0;
      paramIdx <= '0; timePass <= 1'b0; baseline <= 1'b0;
      bestEnergyCfg <= '0; bestTimeCfg <= '0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: if (start) begin
          for (int i = 0; i < 4; i++) cur[i] <= '0;
          paramIdx <= '0; timePass <= 1'b0; baseline <= 1'b1;
          state <= S_LAUNCH;
        end
        S_LAUNCH: state <= S_WAIT;
        S_WAIT:   if (trialDone) state <= timePass ? S_DECIDE : S_MUL0;
        S_MUL0:   state <= S_MUL1;
        S_MUL1:   state <= S_MUL2;
        S_MUL2:   state <= S_DECIDE;
        S_DECIDE: begin
          if (baseline) begin
            baseline <= 1'b0;
            paramIdx <= timePass ? 2'd1 : 2'd0;
            cur[timePass ? 1 : 0] <= FW'(1);
            state <= S_LAUNCH;
          end else if (better && canStep) begin
            cur[paramIdx] <= cur[paramIdx] + FW'(1);
            state <= S_LAUNCH;
          end else begin
            if (!better) cur[paramIdx] <= cur[paramIdx] - FW'(1);
            if (lastParam) state <= S_FINISH;
            else begin
              paramIdx <= paramIdx + 2'd1;
              cur[paramIdx + 2'd1] <= FW'(1);
              state <= S_LAUNCH;
            end
          end
        end
        S_FINISH: begin
          if (!timePass) begin
            bestEnergyCfg <= cfgWord;
            timePass <= 1'b1; baseline <= 1'b1;
            cur[1] <= '0; cur[2] <= '0; cur[3] <= '0;
            state <= S_LAUNCH;
          end else begin
            bestTimeCfg <= cfgWord;
            cur[0] <= bestEnergyCfg[FW-1:0];
            cur[1] <= bestEnergyCfg[2*FW-1:FW];
            cur[2] <= bestEnergyCfg[3*FW-1:2*FW];
            cur[3] <= FW'(bestEnergyCfg[3*FW]);
            state <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_trial_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    trialStart |=> !trialStart);

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> $stable(cfgOut));

  p_wp_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (timePass && state != S_DONE) |-> !cfgOut[3*FW]);

  p_size_fixed_r7: assert property (@(posedge clk) disable iff (!rstN)
    (timePass && $past(timePass)) |-> $stable(cfgOut[FW-1:0]));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(cfgOut)));
endmodule

// File: rtl/cache_explorer.sv
module cache_explorer
  import explorer_pkg::*;
#(
  parameter int NUM_SIZE  = 3,
  parameter int NUM_LINE  = 3,
  parameter int NUM_ASSOC = 3,
  parameter int CNT_W     = 16,
  parameter int COST_W    = 8,
  localparam int FW       = 2,
  localparam int CFG_W    = 3 * FW + 1,
  localparam int ENERGY_W = CNT_W + COST_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                trialDone,
  input  logic [CNT_W-1:0]    hitCount,
  input  logic [CNT_W-1:0]    missCount,
  input  logic [CNT_W-1:0]    cycleCount,
  input  logic [COST_W-1:0]   hitCost,
  input  logic [COST_W-1:0]   missCost,
  input  logic [COST_W-1:0]   staticCost,
  output logic                trialStart,
  output logic [CFG_W-1:0]    cfgOut,
  output logic                done,
  output logic [CFG_W-1:0]    bestEnergyCfg,
  output logic [ENERGY_W-1:0] bestEnergyVal,
  output logic [CFG_W-1:0]    bestTimeCfg,
  output logic [ENERGY_W-1:0] bestTimeVal
);
  ctlStrobes_t ctl;
  logic        better;

  explorer_ctrl #(
    .NUM_SIZE(NUM_SIZE), .NUM_LINE(NUM_LINE), .NUM_ASSOC(NUM_ASSOC),
    .FW(FW), .CFG_W(CFG_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .trialDone(trialDone),
    .better(better), .ctl(ctl), .trialStart(trialStart), .cfgOut(cfgOut),
    .done(done), .bestEnergyCfg(bestEnergyCfg), .bestTimeCfg(bestTimeCfg)
  );

  explorer_datapath #(
    .CNT_W(CNT_W), .COST_W(COST_W), .ENERGY_W(ENERGY_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hitCount(hitCount), .missCount(missCount), .cycleCount(cycleCount),
    .hitCost(hitCost), .missCost(missCost), .staticCost(staticCost),
    .better(better), .bestEnergyVal(bestEnergyVal), .bestTimeVal(bestTimeVal)
  );
endmodule

// File: tb/test_cache_explorer.sv
module test_cache_explorer;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, trialDone = 1'b0;
  logic [15:0] hitCount = '0, missCount = '0, cycleCount = '0;
  logic [7:0]  hitCost, missCost, staticCost;
  logic        trialStart, done;
  logic [6:0]  cfgOut, bestEnergyCfg, bestTimeCfg;
  logic [25:0] bestEnergyVal, bestTimeVal;

  int nCompared = 0, nMismatched = 0, prof = 0, trialIdx = 0;
  int expCfg [32];
  int expN, eTrials, expECfg, expEVal, expTCfg, expTVal;
  bit finished = 0;

  always #4 clk = ~clk;

  cache_explorer i_cache_explorer (
    .clk(clk), .rstN(rstN), .start(start), .trialDone(trialDone),
    .hitCount(hitCount), .missCount(missCount), .cycleCount(cycleCount),
    .hitCost(hitCost), .missCost(missCost), .staticCost(staticCost),
    .trialStart(trialStart), .cfgOut(cfgOut), .done(done),
    .bestEnergyCfg(bestEnergyCfg), .bestEnergyVal(bestEnergyVal),
    .bestTimeCfg(bestTimeCfg), .bestTimeVal(bestTimeVal)
  );

  task automatic chk(input string req, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nMismatched++;
      $display("FAIL %s prof=%0d actual=%0d expected=%0d", req, prof, act, exp);
    end
  endtask

  // field layout: [1:0] size, [3:2] line, [5:4] assoc, [6] way prediction
  function automatic int hitsOf(int c, int p);
    int s = c & 3, l = (c >> 2) & 3, a = (c >> 4) & 3;
    if (p == 7) return 300;
    return 200 + 37*s + (l*13 + p*7) % 29 + a*a*(p%3)*11;
  endfunction
  function automatic int missOf(int c, int p);
    int s = c & 3, l = (c >> 2) & 3, a = (c >> 4) & 3, w = (c >> 6) & 1;
    if (p == 7) return 100 - 10*s;
    return 120 - 20*s + (a*17 + l*5 + p*11) % 23 + w*3;
  endfunction
  function automatic int cycOf(int c, int p);
    int s = c & 3, l = (c >> 2) & 3, a = (c >> 4) & 3, w = (c >> 6) & 1;
    if (p == 7) return 2000 - 50*s;
    return 1000 + missOf(c, p)*8 - w*((p%2) != 0 ? 40 : 5) + l*l*9 - a*(p%4)*12;
  endfunction
  function automatic int hcOf(int c, int p);
    return (p == 7) ? 3 : 2 + (c & 3) + ((c >> 4) & 3) + ((c >> 6) & 1);
  endfunction
  function automatic int mcOf(int c, int p);
    return (p == 7) ? 20 : 20 + 3*((c >> 2) & 3);
  endfunction
  function automatic int scOf(int c, int p);
    return (p == 7) ? 2 : 1 + (c & 3);
  endfunction
  function automatic int energyOf(int c, int p);  // R3
    return hitsOf(c,p)*hcOf(c,p) + missOf(c,p)*mcOf(c,p) + cycOf(c,p)*scOf(c,p);
  endfunction
  function automatic int packCfg(int f[4]);
    return f[0] | (f[1] << 2) | (f[2] << 4) | (f[3] << 6);
  endfunction

  always_comb begin
    hitCost    = 8'(hcOf(int'(cfgOut), prof));
    missCost   = 8'(mcOf(int'(cfgOut), prof));
    staticCost = 8'(scOf(int'(cfgOut), prof));
  end

  task automatic buildModel(input int p);
    int f[4] = '{0, 0, 0, 0};
    int opts[4] = '{3, 3, 3, 2};
    int best, m;
    expN = 0;
    expCfg[expN++] = packCfg(f);
    best = energyOf(packCfg(f), p);
    for (int k = 0; k < 4; k++) begin
      for (int v = 1; v < opts[k]; v++) begin
        f[k] = v; expCfg[expN++] = packCfg(f); m = energyOf(packCfg(f), p);
        if (m < best) best = m;
        else begin f[k] = v - 1; break; end
      end
    end
    eTrials = expN; expECfg = packCfg(f); expEVal = best;
    f[1] = 0; f[2] = 0; f[3] = 0;
    expCfg[expN++] = packCfg(f);
    best = cycOf(packCfg(f), p);
    for (int k = 1; k < 3; k++) begin
      for (int v = 1; v < opts[k]; v++) begin
        f[k] = v; expCfg[expN++] = packCfg(f); m = cycOf(packCfg(f), p);
        if (m < best) best = m;
        else begin f[k] = v - 1; break; end
      end
    end
    expTCfg = packCfg(f); expTVal = best;
  endtask

  // cache side: answer each launched trial after a varying latency
  initial begin
    int c;
    forever begin
      @(negedge clk);
      if (rstN && trialStart) begin
        c = int'(cfgOut);
        if (trialIdx >= expN) chk("R9 extra trial", trialIdx, expN);
        else if (trialIdx == 0) chk("R2 first trial cfg", c, expCfg[0]);
        else if (trialIdx < eTrials) chk("R4/R5 energy pass cfg", c, expCfg[trialIdx]);
        else chk("R7 speed pass cfg", c, expCfg[trialIdx]);
        repeat (1 + trialIdx % 4) @(negedge clk);
        chk("R2 cfg held in trial", int'(cfgOut), c);
        hitCount = 16'(hitsOf(c, prof)); missCount = 16'(missOf(c, prof));
        cycleCount = 16'(cycOf(c, prof)); trialDone = 1'b1;
        trialIdx++;
        @(negedge clk);
        trialDone = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCompared++; nMismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    expN = 0; eTrials = 0;
    repeat (3) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 trialStart after reset", int'(trialStart), 0);
    chk("R1 cfgOut after reset", int'(cfgOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      int waited = 0;
      prof = p; buildModel(p); trialIdx = 0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk("R8 done cleared by start", int'(done), 0);
      while (!done && waited < 3000) begin @(negedge clk); waited++; end
      repeat (8) @(negedge clk);
      chk("R8 done raised", int'(done), 1);
      chk("R8 cfgOut holds energy choice", int'(cfgOut), expECfg);
      chk("R9 trial count", trialIdx, expN);
      if (p == 7) chk("R6 ties keep smaller index", int'(bestEnergyCfg), expECfg);
      else chk("R4 best energy cfg", int'(bestEnergyCfg), expECfg);
      chk("R3 best energy value", int'(bestEnergyVal), expEVal);
      chk("R3 value matches cfg", int'(bestEnergyVal), energyOf(int'(bestEnergyCfg), p));
      chk("R7 best time cfg", int'(bestTimeCfg), expTCfg);
      chk("R7 best time value", int'(bestTimeVal), expTVal);
    end
    finish_run();
  end
endmodule